// File: doc/BRIEF.md
# Bit-Plane Mask, Blink and Overlay Selector

This block sits in the pixel path of a colour look-up stage. Each clock it takes one pixel value and a pair of overlay bits. Two masks act on every bit plane. A display mask switches planes on or off, and a blink mask names the planes that vanish during the off half of the blink cycle. The same masking is then applied to the overlay bits, using their own pair of masks. From the result the block decides whether the colour comes from the palette memory, which it addresses with the masked pixel, or from an overlay register, which it indexes with the masked overlay bits.

The blink cycle is counted in frames. A frame boundary is inferred when the blank input is held low over a long run of load strobes. A two-bit rate field selects one of four periods and duty ratios. The visible blink phase is updated only at the moment a retrace is recognised, so a plane can never appear or disappear partway down the screen. The palette memory and the converters that follow it are outside this block.

Top module: `plane_select`

## Requirements
- R1: In the same cycle, `pal_addr` equals `pixel & read_mask`, with bit 0 as the palette address LSB, while `blink_on` is 1.
- R2: While `blink_on` is 0, the bits set in `blink_mask` are also cleared from `pal_addr`.
- R3: `ovl_idx` equals `ovl & ovl_read_mask`, and while `blink_on` is 0 it also has the bits of `ovl_blink_mask` cleared. Bit 0 of `ovl_idx` comes from `ovl[0]`.
- R4: `use_palette` is 1 exactly when `pal_en` is 1 and the masked overlay value is zero. Otherwise the colour comes from overlay register `ovl_idx`.
- R5: A load is a cycle with `load` at 1. `in_retrace` goes to 1 on the clock edge that samples the 256th consecutive load with `blank_n` at 0. A load with `blank_n` at 1 clears the run and `in_retrace`. Cycles without `load` neither count nor clear, whatever `blank_n` is.
- R6: One blank-low interval advances the frame count at most once, however long it lasts. An interval shorter than 256 loads does not advance it.
- R7: The frame period is 16, 32, 64 or 128 frames for `blink_rate` 0, 1, 2 or 3. The on-frames are 8, 16, 48 or 96, which is 50% duty for rates 0 and 1 and 75% for rates 2 and 3. Each retrace advances the frame count by one and wraps it to 0 when it reaches the period. `blink_on` becomes 1 when the new count is below the on-frames.
- R8: `blink_on` changes only on the clock edge of a recognised retrace. It never changes during active display or when `blink_rate` is written.
- R9: After a synchronous reset (`rst_n` at 0), `blink_on` is 1, `in_retrace` is 0, and the frame and load counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Load strobe, one clock wide per load cycle |
| blank_n | input | 1 | Blank, low while blanking |
| pal_en | input | 1 | Palette enable command bit |
| blink_rate | input | 2 | Blink rate and duty select |
| read_mask | input | 8 | Display enable per pixel plane |
| blink_mask | input | 8 | Blink enable per pixel plane |
| ovl_read_mask | input | 2 | Display enable per overlay plane |
| ovl_blink_mask | input | 2 | Blink enable per overlay plane |
| pixel | input | 8 | Pixel value |
| ovl | input | 2 | Overlay bits |
| pal_addr | output | 8 | Masked palette address |
| ovl_idx | output | 2 | Masked overlay register index |
| use_palette | output | 1 | 1 selects palette, 0 selects overlay register |
| blink_on | output | 1 | Current visible blink phase |
| in_retrace | output | 1 | Retrace currently recognised |

## Verification
The hardest states to reach are the ones deep in the blink cycle: the on/off boundary at 96 frames of the slowest rate, and the wrap back to zero. Each of those frames needs 256 blank-low loads. The stimulus therefore runs full frames back to back and switches the rate mid-sequence. It scatters non-load cycles at random through the blanking, with random `blank_n`, and places directed intervals of 255 and 300 loads around the threshold. Between frames, random pixels, overlays and masks are checked against the expected blink phase.

// File: rtl/plane_sel_pkg.sv
// Shared helpers for the plane selector: blink period and on-time per rate code.
// Assumes the rate code is two bits and the base period is a power of two.
package plane_sel_pkg;

    localparam int RATE_W = 2;

    // Frame period for a rate code: base, 2x, 4x, 8x.
    function automatic int period_of(input int base, input logic [RATE_W-1:0] rate);
        return base << rate;
    endfunction

    // On-frames: half the period for codes 0/1, three quarters for codes 2/3.
    function automatic int on_of(input int base, input logic [RATE_W-1:0] rate);
        int p;
        p = base << rate;
        return rate[1] ? (p - (p >> 2)) : (p >> 1);
    endfunction

endpackage

// File: rtl/plane_mask.sv
// Per-plane mask stage: keeps a bit when its display enable is set, and drops
// it while blinking is in the off phase if its blink enable is set.
// Assumes all vectors share width W; purely combinational.
module plane_mask #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    input  logic [W-1:0] show,
    input  logic [W-1:0] blink,
    input  logic         blink_off,
    output logic [W-1:0] masked
);
    // One gate per plane.
    for (genvar b = 0; b < W; b++) begin : g_plane
        assign masked[b] = data[b] & show[b] & ~(blink_off & blink[b]);
    end
endmodule

// File: rtl/retrace_detect.sv
// Recognises vertical retrace from a run of load strobes with blank low.
// Assumes load is one clock wide; cycles without load leave the run untouched.
// Emits one tick per blank-low interval, on the edge sampling the LOADS-th load.
module retrace_detect #(
    parameter int LOADS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic blank_n,
    output logic tick,
    output logic in_retrace
);
    localparam int CNT_W = $clog2(LOADS + 1);

    logic [CNT_W-1:0] run_cnt;

    // Tick when the sampled load completes the run.
    assign tick       = load & ~blank_n & (run_cnt == CNT_W'(LOADS - 1));
    assign in_retrace = (run_cnt == CNT_W'(LOADS));

    // Count blank-low loads, saturate at LOADS, clear on a blank-high load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (load) begin
            if (blank_n)
                run_cnt <= '0;
            else if (run_cnt != CNT_W'(LOADS))
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assert_clear_on_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && blank_n) |=> !in_retrace);

    assert_rise_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_retrace) |-> $past(load && !blank_n));

    assert_single_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (in_retrace && !tick));
endmodule

// File: rtl/blink_timer.sv
// Frame-based blink phase generator. Advances a frame count on each retrace
// tick and updates the visible phase only then.
// Assumes the tick comes from the retrace detector, at most once per frame.
module blink_timer
    import plane_sel_pkg::*;
#(
    parameter int BASE_FRAMES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              blink_on
);
    localparam int FC_W = $clog2(BASE_FRAMES * 8);

    logic [FC_W-1:0] frame_cnt;
    logic [FC_W:0]   period;
    logic [FC_W:0]   on_frames;
    logic [FC_W:0]   nxt;

    // Next count with wrap at the selected period.
    always_comb begin
        period    = (FC_W+1)'(period_of(BASE_FRAMES, rate));
        on_frames = (FC_W+1)'(on_of(BASE_FRAMES, rate));
        nxt       = {1'b0, frame_cnt} + 1'b1;
        if (nxt >= period)
            nxt = '0;
    end

    // Advance count and phase on a retrace tick only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            blink_on  <= 1'b1;
        end else if (tick) begin
            frame_cnt <= nxt[FC_W-1:0];
            blink_on  <= (nxt < on_frames);
        end
    end

    assert_phase_at_retrace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(blink_on) |-> $past(tick));
endmodule

// File: rtl/plane_select.sv
// Top of the bit-plane selector: masks pixel and overlay planes, runs the
// blink timer from retrace recognition, and picks palette or overlay source.
// Assumes load strobes arrive at a steady rate; pixel path is combinational.
module plane_select
    import plane_sel_pkg::*;
#(
    parameter int PIX_W         = 8,
    parameter int OVL_W         = 2,
    parameter int RETRACE_LOADS = 256,
    parameter int BASE_FRAMES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              blank_n,
    input  logic              pal_en,
    input  logic [RATE_W-1:0] blink_rate,
    input  logic [PIX_W-1:0]  read_mask,
    input  logic [PIX_W-1:0]  blink_mask,
    input  logic [OVL_W-1:0]  ovl_read_mask,
    input  logic [OVL_W-1:0]  ovl_blink_mask,
    input  logic [PIX_W-1:0]  pixel,
    input  logic [OVL_W-1:0]  ovl,
    output logic [PIX_W-1:0]  pal_addr,
    output logic [OVL_W-1:0]  ovl_idx,
    output logic              use_palette,
    output logic              blink_on,
    output logic              in_retrace
);
    logic frame_tick;

    retrace_detect #(.LOADS(RETRACE_LOADS)) u_retrace (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .blank_n    (blank_n),
        .tick       (frame_tick),
        .in_retrace (in_retrace)
    );

    blink_timer #(.BASE_FRAMES(BASE_FRAMES)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (frame_tick),
        .rate     (blink_rate),
        .blink_on (blink_on)
    );

    plane_mask #(.W(PIX_W)) u_pix_mask (
        .data      (pixel),
        .show      (read_mask),
        .blink     (blink_mask),
        .blink_off (~blink_on),
        .masked    (pal_addr)
    );

    plane_mask #(.W(OVL_W)) u_ovl_mask (
        .data      (ovl),
        .show      (ovl_read_mask),
        .blink     (ovl_blink_mask),
        .blink_off (~blink_on),
        .masked    (ovl_idx)
    );

    // Palette only when enabled and no surviving overlay plane.
    assign use_palette = pal_en & ~(|ovl_idx);

    assert_addr_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_addr & ~read_mask) == '0);

    assert_blink_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_on |-> ((pal_addr & blink_mask) == '0));

    assert_ovl_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_idx & ~ovl_read_mask) == '0);

    assert_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        use_palette |-> (pal_en && ovl_idx == '0));
endmodule

// File: tb/plane_select_test.sv
module plane_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int LOADS      = 256;
    localparam int BASE       = 16;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n, load, blank_n, pal_en;
    logic [1:0] blink_rate;
    logic [7:0] read_mask, blink_mask, pixel, pal_addr;
    logic [1:0] ovl_read_mask, ovl_blink_mask, ovl, ovl_idx;
    logic       use_palette, blink_on, in_retrace;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int exp_fc = 0;
    bit exp_blink = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    plane_select uut (
        .clk(clk), .rst_n(rst_n), .load(load), .blank_n(blank_n), .pal_en(pal_en),
        .blink_rate(blink_rate), .read_mask(read_mask), .blink_mask(blink_mask),
        .ovl_read_mask(ovl_read_mask), .ovl_blink_mask(ovl_blink_mask),
        .pixel(pixel), .ovl(ovl), .pal_addr(pal_addr), .ovl_idx(ovl_idx),
        .use_palette(use_palette), .blink_on(blink_on), .in_retrace(in_retrace)
    );

    function automatic int per_f(input int r);  return BASE << r; endfunction
    function automatic int on_f(input int r);
        return (r >= 2) ? (per_f(r) * 3 / 4) : (per_f(r) / 2);
    endfunction
    function automatic logic [7:0] mask8(input logic [7:0] d, rm, bm, input bit on);
        return d & rm & ~(on ? 8'h00 : bm);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one clock; drive and sample 1 time unit after the rising edge.
    task automatic cyc(input bit ld, input bit bn);
        load = ld; blank_n = bn;
        @(posedge clk); #1;
    endtask

    // Random pixel-path check against the model blink phase (R1-R4).
    task automatic pix_check(input bit directed_ones);
        logic [7:0] ep; logic [1:0] eo; bit eu;
        pixel = 8'($urandom); ovl = 2'($urandom);
        pal_en = 1'($urandom);
        read_mask = directed_ones ? 8'hFF : 8'($urandom);
        blink_mask = 8'($urandom);
        ovl_read_mask = directed_ones ? 2'b11 : 2'($urandom);
        ovl_blink_mask = 2'($urandom);
        #1;
        ep = mask8(pixel, read_mask, blink_mask, exp_blink);
        eo = ovl & ovl_read_mask & ~(exp_blink ? 2'b00 : ovl_blink_mask);
        eu = pal_en && (eo == 2'b00);
        check(pal_addr == ep, exp_blink ? "R1" : "R2", pal_addr, ep);
        check(ovl_idx == eo, "R3", ovl_idx, eo);
        check(use_palette == eu, "R4", use_palette, eu);
    endtask

    // One frame: short active part with pixel checks, then nlow blank-low loads.
    task automatic run_frame(input int nlow);
        bit prev;
        for (int a = 0; a < 4; a++) begin
            cyc(1'b1, 1'b1);
            pix_check(a == 0);
            check(blink_on == exp_blink, "R8", blink_on, exp_blink);
        end
        check(in_retrace == 1'b0, "R5", in_retrace, 0);
        for (int i = 0; i < nlow; i++) begin
            if (($urandom % 4) == 0) cyc(1'b0, 1'($urandom));
            prev = exp_blink;
            cyc(1'b1, 1'b0);
            if (i == LOADS - 2) begin
                check(in_retrace == 1'b0, "R5", in_retrace, 0);
                check(blink_on == prev, "R8", blink_on, prev);
            end
            if (i == LOADS - 1) begin
                exp_fc = (exp_fc + 1 >= per_f(blink_rate)) ? 0 : exp_fc + 1;
                exp_blink = (exp_fc < on_f(blink_rate));
                check(in_retrace == 1'b1, "R5", in_retrace, 1);
                check(blink_on == exp_blink, "R7", blink_on, exp_blink);
            end
        end
        if (nlow > LOADS)
            check(blink_on == exp_blink, "R6", blink_on, exp_blink);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; load = 0; blank_n = 1; pal_en = 1; blink_rate = 0;
        read_mask = 8'hFF; blink_mask = 8'hFF; ovl_read_mask = 2'b11; ovl_blink_mask = 2'b11;
        pixel = 8'h5A; ovl = 2'b00;
        repeat (3) cyc(1'b0, 1'b0);
        rst_n = 1;
        #1;
        // R9: reset state
        check(blink_on == 1'b1, "R9", blink_on, 1);
        check(in_retrace == 1'b0, "R9", in_retrace, 0);
        check(pal_addr == 8'h5A, "R1", pal_addr, 8'h5A);
        check(use_palette == 1'b1, "R4", use_palette, 1);
        // R4: palette disabled forces overlay source
        pal_en = 0; #1;
        check(use_palette == 1'b0, "R4", use_palette, 0);
        // R3: masked-off overlay bit cannot force overlay
        pal_en = 1; ovl = 2'b10; ovl_read_mask = 2'b01; #1;
        check(use_palette == 1'b1 && ovl_idx == 2'b00, "R3", ovl_idx, 0);

        // R6: interval one load short gives no tick
        run_frame(LOADS - 1);
        cyc(1'b1, 1'b1);
        check(blink_on == exp_blink, "R6", blink_on, exp_blink);
        check(exp_fc == 0, "R6", exp_fc, 0);
        // R6: long interval ticks once
        run_frame(LOADS + 44);

        for (int f = 0; f < 18; f++) run_frame(LOADS);
        blink_rate = 1; #1;
        check(blink_on == exp_blink, "R8", blink_on, exp_blink);
        for (int f = 0; f < 20; f++) run_frame(LOADS);
        blink_rate = 2;
        for (int f = 0; f < 50; f++) run_frame(LOADS);
        blink_rate = 3;
        for (int f = 0; f < 100; f++) run_frame(LOADS);
        for (int k = 0; k < 40; k++) pix_check(1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule